// File: doc/BRIEF.md
# Flash Byte Programming Sequencer

This block sits on the host side of a parallel boot-block flash bus and turns a stream of byte-write requests into the command traffic the flash needs. Each accepted request carries a target address, a data byte, a flag marking the last byte of a job and a flag choosing whether the outcome is checked after every byte or once for the whole job. For each byte the sequencer issues the program-setup command and then the address/data write. It reads the device status repeatedly, with a fresh chip-enable and output-enable cycle for each read, until the ready bit comes up.

Once the device is ready, the sequencer classifies the status. A supply-range fault takes priority over a program fault. On any fault it issues the clear-status command before anything else reaches the bus, and it ends every job by returning the flash to array-read mode. Targets inside the boot region raise an unlock control before the first command, and it stays raised until the ready status has been seen. A bounded poll count turns a device that never becomes ready into a timeout result. The timeout aborts the job, and the rest of that job's requests are accepted and dropped.

Bus strobe setup, low time and hold are counted in system clocks and set by parameters. The boot region may sit at the bottom or at the top of the address space.

Top module: `flash_prog_seq`

## Requirements
- R1: Each accepted byte produces a write of 40h at the target address, followed by a write of the data byte at the same address.
- R2: After the data write, status is read at the target address with a separate chip-enable/output-enable cycle per read until bit 7 reads 1. The data bus is never driven while output enable is low.
- R3: The status is classified with bit 3 taking priority over bit 4. res_code is 1 (supply) when bit 3 is set, else 2 (program) when bit 4 is set, else 0 (ok).
- R4: With req_check_each high, one single-cycle res_valid follows each byte. With it low, only the byte flagged req_last yields a result, and that result reflects status accumulated over the whole job.
- R5: When a result is nonzero, a write of 50h at the target address follows before any other write.
- R6: After the last byte of a job, or after an abort, a write of FFh at the target address ends the bus activity for that byte.
- R7: For a target inside the boot region, fl_boot_unlock rises while the bus is idle before the 40h write and stays high through the ready status read. It is low again before any following write and before the result. It never rises for other targets. The boot region is the lowest BOOT_BYTES addresses, or the highest when BOOT_AT_TOP is set.
- R8: If POLL_MAX status reads all show bit 7 at 0, the byte reports res_code 3 (timeout) after the clear and read-array writes. Any remaining requests of that job are accepted with no bus activity and no result.
- R9: Every write holds fl_we_n low for exactly WE_LOW_CYC clocks with chip enable low, and the address and data stay stable throughout.
- R10: After reset the bus is idle: all strobes high, data not driven, unlock low, res_valid low and req_ready high. req_ready is high only while no bus cycle is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Byte request present |
| req_ready | output | 1 | Sequencer can take a request |
| req_addr | input | ADDR_W | Target byte address |
| req_data | input | 8 | Byte to program |
| req_last | input | 1 | Request is the last byte of its job |
| req_check_each | input | 1 | 1: check status after each byte, 0: once per job |
| res_valid | output | 1 | Result strobe, one cycle |
| res_code | output | 2 | 0 ok, 1 supply range, 2 program fault, 3 timeout |
| fl_ce_n | output | 1 | Flash chip enable, active low |
| fl_oe_n | output | 1 | Flash output enable, active low |
| fl_we_n | output | 1 | Flash write enable, active low |
| fl_addr | output | ADDR_W | Flash address |
| fl_dq_o | output | 8 | Data driven toward the flash |
| fl_dq_oe | output | 1 | Data output enable toward the flash pins |
| fl_dq_i | input | 8 | Data returned from the flash |
| fl_boot_unlock | output | 1 | Boot region unlock control |

## Verification
A behavioural flash model on the bench answers status reads with a programmable busy count and sticky fault bits. The scoreboard predicts every bus write and every result. Per-byte jobs with single faults, with both faults together and with none separate the classification priority and the clear/read-array ordering. Batch jobs with a fault in a middle byte show that results are held back and that fault status accumulates across the job. Busy counts just below and at the poll limit separate a slow success from a timeout. Requests sent after a timeout show the flush. Boot and non-boot targets show whether the unlock is raised for the right bytes and whether it is dropped before the closing writes.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

   localparam logic [7:0] CMD_PROG_SETUP = 8'h40;
   localparam logic [7:0] CMD_CLR_STAT   = 8'h50;
   localparam logic [7:0] CMD_READ_ARR   = 8'hFF;

   localparam int SR_BIT_READY  = 7;
   localparam int SR_BIT_PROG   = 4;
   localparam int SR_BIT_SUPPLY = 3;

   typedef enum logic [1:0] {
      RES_OK      = 2'd0,
      RES_SUPPLY  = 2'd1,
      RES_PROG    = 2'd2,
      RES_TIMEOUT = 2'd3
   } res_code_e;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_UNLOCK,
      ST_SETUP_CMD,
      ST_DATA_WR,
      ST_POLL,
      ST_CLASSIFY,
      ST_CLEAR,
      ST_READ_ARR,
      ST_REPORT
   } seq_state_e;

   typedef enum logic [1:0] {
      PH_IDLE,
      PH_SETUP,
      PH_STROBE,
      PH_HOLD
   } bus_phase_e;

endpackage

// File: rtl/flash_bus_cycle.sv
module flash_bus_cycle
   import flash_seq_pkg::*;
#(
   parameter int ADDR_W     = 17,
   parameter int SETUP_CYC  = 1,
   parameter int STROBE_CYC = 3,
   parameter int HOLD_CYC   = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              is_read,
   input  logic [ADDR_W-1:0] addr,
   input  logic [7:0]        wdata,
   output logic              done,
   output logic [7:0]        rdata,
   output logic              ce_n,
   output logic              oe_n,
   output logic              we_n,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [7:0]        dq_o,
   output logic              dq_oe,
   input  logic [7:0]        dq_i
);

   localparam int MAX_A = (SETUP_CYC > STROBE_CYC) ? SETUP_CYC : STROBE_CYC;
   localparam int MAX_C = (MAX_A > HOLD_CYC) ? MAX_A : HOLD_CYC;
   localparam int CW    = $clog2(MAX_C + 1);

   bus_phase_e        phase;
   logic [CW-1:0]     cnt;
   logic              rd_q;
   logic [ADDR_W-1:0] addr_q;
   logic [7:0]        data_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase  <= PH_IDLE;
         cnt    <= '0;
         rd_q   <= 1'b0;
         addr_q <= '0;
         data_q <= '0;
         rdata  <= '0;
         done   <= 1'b0;
      end else begin
         done <= 1'b0;
         unique case (phase)
            PH_IDLE: begin
               if (start) begin
                  phase  <= PH_SETUP;
                  cnt    <= '0;
                  rd_q   <= is_read;
                  addr_q <= addr;
                  data_q <= wdata;
               end
            end
            PH_SETUP: begin
               if (cnt == CW'(SETUP_CYC - 1)) begin
                  phase <= PH_STROBE;
                  cnt   <= '0;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            PH_STROBE: begin
               if (cnt == CW'(STROBE_CYC - 1)) begin
                  if (rd_q) rdata <= dq_i;
                  phase <= PH_HOLD;
                  cnt   <= '0;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            PH_HOLD: begin
               if (cnt == CW'(HOLD_CYC - 1)) begin
                  phase <= PH_IDLE;
                  cnt   <= '0;
                  done  <= 1'b1;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            default: phase <= PH_IDLE;
         endcase
      end
   end

   always_comb begin
      ce_n     = (phase == PH_IDLE);
      we_n     = !((phase == PH_STROBE) && !rd_q);
      oe_n     = !((phase == PH_STROBE) && rd_q);
      dq_oe    = (phase != PH_IDLE) && !rd_q;
      bus_addr = addr_q;
      dq_o     = data_q;
   end

endmodule

// File: rtl/flash_status_class.sv
module flash_status_class
   import flash_seq_pkg::*;
(
   input  logic [7:0] status,
   output logic       ready,
   output logic       fault,
   output res_code_e  code
);

   always_comb begin
      ready = status[SR_BIT_READY];
      if (status[SR_BIT_SUPPLY])     code = RES_SUPPLY;
      else if (status[SR_BIT_PROG])  code = RES_PROG;
      else                           code = RES_OK;
      fault = (code != RES_OK);
   end

endmodule

// File: rtl/flash_boot_decode.sv
module flash_boot_decode #(
   parameter int ADDR_W      = 17,
   parameter int BOOT_BYTES  = 8192,
   parameter bit BOOT_AT_TOP = 1'b0
) (
   input  logic [ADDR_W-1:0] addr,
   output logic              in_boot
);

   localparam logic [ADDR_W-1:0] TOP_BASE = ADDR_W'((1 << ADDR_W) - BOOT_BYTES);
   localparam logic [ADDR_W-1:0] BOT_LIM  = ADDR_W'(BOOT_BYTES);

   generate
      if (BOOT_AT_TOP) begin : g_top
         assign in_boot = (addr >= TOP_BASE);
      end else begin : g_bottom
         assign in_boot = (addr < BOT_LIM);
      end
   endgenerate

endmodule

// File: rtl/flash_prog_seq.sv
module flash_prog_seq
   import flash_seq_pkg::*;
#(
   parameter int ADDR_W      = 17,
   parameter int SETUP_CYC   = 1,
   parameter int WE_LOW_CYC  = 3,
   parameter int HOLD_CYC    = 1,
   parameter int POLL_MAX    = 64,
   parameter int BOOT_BYTES  = 8192,
   parameter bit BOOT_AT_TOP = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [7:0]        req_data,
   input  logic              req_last,
   input  logic              req_check_each,
   output logic              res_valid,
   output logic [1:0]        res_code,
   output logic              fl_ce_n,
   output logic              fl_oe_n,
   output logic              fl_we_n,
   output logic [ADDR_W-1:0] fl_addr,
   output logic [7:0]        fl_dq_o,
   output logic              fl_dq_oe,
   input  logic [7:0]        fl_dq_i,
   output logic              fl_boot_unlock
);

   localparam int PCW = $clog2(POLL_MAX + 1);

   initial begin
      assert (ADDR_W >= 2 && ADDR_W <= 30) else $error("ADDR_W out of range");
      assert (SETUP_CYC >= 1) else $error("SETUP_CYC must be at least 1");
      assert (WE_LOW_CYC >= 1) else $error("WE_LOW_CYC must be at least 1");
      assert (HOLD_CYC >= 1) else $error("HOLD_CYC must be at least 1");
      assert (POLL_MAX >= 1) else $error("POLL_MAX must be at least 1");
      assert (BOOT_BYTES >= 1 && BOOT_BYTES < (1 << ADDR_W))
         else $error("BOOT_BYTES must fit inside the address space");
   end

   seq_state_e        state;
   logic [ADDR_W-1:0] r_addr;
   logic [7:0]        r_data;
   logic              r_last;
   logic              r_each;
   logic              r_abort;
   logic              r_flush;
   logic              launched;
   logic [PCW-1:0]    poll_cnt;
   logic [7:0]        stat_q;
   res_code_e         err_q;
   logic              unlock_q;

   logic              bc_start;
   logic              bc_read;
   logic [7:0]        bc_wdata;
   logic              bc_done;
   logic [7:0]        bc_rdata;
   logic              req_in_boot;
   logic              cls_ready;
   logic              cls_fault;
   res_code_e         cls_code;
   logic              poll_ready;
   logic              poll_fault_unused;
   res_code_e         poll_code_unused;

   flash_boot_decode #(
      .ADDR_W     (ADDR_W),
      .BOOT_BYTES (BOOT_BYTES),
      .BOOT_AT_TOP(BOOT_AT_TOP)
   ) boot_dec_i (
      .addr   (req_addr),
      .in_boot(req_in_boot)
   );

   flash_status_class poll_cls_i (
      .status(bc_rdata),
      .ready (poll_ready),
      .fault (poll_fault_unused),
      .code  (poll_code_unused)
   );

   flash_status_class final_cls_i (
      .status(stat_q),
      .ready (cls_ready),
      .fault (cls_fault),
      .code  (cls_code)
   );

   flash_bus_cycle #(
      .ADDR_W    (ADDR_W),
      .SETUP_CYC (SETUP_CYC),
      .STROBE_CYC(WE_LOW_CYC),
      .HOLD_CYC  (HOLD_CYC)
   ) bus_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (bc_start),
      .is_read (bc_read),
      .addr    (r_addr),
      .wdata   (bc_wdata),
      .done    (bc_done),
      .rdata   (bc_rdata),
      .ce_n    (fl_ce_n),
      .oe_n    (fl_oe_n),
      .we_n    (fl_we_n),
      .bus_addr(fl_addr),
      .dq_o    (fl_dq_o),
      .dq_oe   (fl_dq_oe),
      .dq_i    (fl_dq_i)
   );

   // Bus command for the current state; a cycle is launched once per state visit.
   always_comb begin
      bc_read  = 1'b0;
      bc_wdata = CMD_READ_ARR;
      bc_start = 1'b0;
      unique case (state)
         ST_SETUP_CMD: begin bc_wdata = CMD_PROG_SETUP; bc_start = !launched; end
         ST_DATA_WR:   begin bc_wdata = r_data;         bc_start = !launched; end
         ST_POLL:      begin bc_read  = 1'b1;           bc_start = !launched; end
         ST_CLEAR:     begin bc_wdata = CMD_CLR_STAT;   bc_start = !launched; end
         ST_READ_ARR:  begin bc_wdata = CMD_READ_ARR;   bc_start = !launched; end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         r_addr   <= '0;
         r_data   <= '0;
         r_last   <= 1'b0;
         r_each   <= 1'b0;
         r_abort  <= 1'b0;
         r_flush  <= 1'b0;
         launched <= 1'b0;
         poll_cnt <= '0;
         stat_q   <= '0;
         err_q    <= RES_OK;
         unlock_q <= 1'b0;
      end else begin
         if (bc_start)     launched <= 1'b1;
         else if (bc_done) launched <= 1'b0;

         unique case (state)
            ST_IDLE: begin
               if (req_valid) begin
                  if (r_flush) begin
                     r_flush <= !req_last;
                  end else begin
                     r_addr   <= req_addr;
                     r_data   <= req_data;
                     r_last   <= req_last;
                     r_each   <= req_check_each;
                     r_abort  <= 1'b0;
                     err_q    <= RES_OK;
                     poll_cnt <= '0;
                     if (req_in_boot) begin
                        unlock_q <= 1'b1;
                        state    <= ST_UNLOCK;
                     end else begin
                        state    <= ST_SETUP_CMD;
                     end
                  end
               end
            end
            ST_UNLOCK: state <= ST_SETUP_CMD;
            ST_SETUP_CMD: if (bc_done) state <= ST_DATA_WR;
            ST_DATA_WR: if (bc_done) state <= ST_POLL;
            ST_POLL: begin
               if (bc_done) begin
                  if (poll_ready) begin
                     unlock_q <= 1'b0;
                     stat_q   <= bc_rdata;
                     state    <= (r_each || r_last) ? ST_CLASSIFY : ST_IDLE;
                  end else if (poll_cnt == PCW'(POLL_MAX - 1)) begin
                     unlock_q <= 1'b0;
                     err_q    <= RES_TIMEOUT;
                     r_abort  <= 1'b1;
                     state    <= ST_CLEAR;
                  end else begin
                     poll_cnt <= poll_cnt + 1'b1;
                  end
               end
            end
            ST_CLASSIFY: begin
               err_q <= cls_code;
               if (cls_fault)   state <= ST_CLEAR;
               else if (r_last) state <= ST_READ_ARR;
               else             state <= ST_REPORT;
            end
            ST_CLEAR: begin
               if (bc_done) begin
                  if (r_abort && !r_last) r_flush <= 1'b1;
                  state <= (r_last || r_abort) ? ST_READ_ARR : ST_REPORT;
               end
            end
            ST_READ_ARR: if (bc_done) state <= ST_REPORT;
            ST_REPORT:   state <= ST_IDLE;
            default:     state <= ST_IDLE;
         endcase
      end
   end

   // The final classifier only sees latched ready statuses.
   logic unused_ok;
   assign unused_ok = cls_ready ^ poll_fault_unused ^ (^poll_code_unused);

   assign req_ready      = (state == ST_IDLE);
   assign res_valid      = (state == ST_REPORT);
   assign res_code       = err_q;
   assign fl_boot_unlock = unlock_q;

endmodule

// File: rtl/flash_prog_seq_chk.sv
module flash_prog_seq_chk #(
   parameter int ADDR_W     = 17,
   parameter int WE_LOW_CYC = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_ready,
   input logic              res_valid,
   input logic              fl_ce_n,
   input logic              fl_oe_n,
   input logic              fl_we_n,
   input logic [ADDR_W-1:0] fl_addr,
   input logic [7:0]        fl_dq_o,
   input logic              fl_dq_oe,
   input logic              fl_boot_unlock
);

   localparam int WCW = $clog2(WE_LOW_CYC + 2);

   logic [WCW-1:0] we_low_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                  we_low_cnt <= '0;
      else if (!fl_we_n && we_low_cnt != '1)       we_low_cnt <= we_low_cnt + 1'b1;
      else if (fl_we_n)                            we_low_cnt <= '0;
   end

   assert_we_width_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fl_we_n) |-> (we_low_cnt == WCW'(WE_LOW_CYC)));

   assert_we_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!fl_we_n && $past(!fl_we_n)) |-> ($stable(fl_addr) && $stable(fl_dq_o)));

   assert_strobe_ce_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!fl_we_n || !fl_oe_n) |-> !fl_ce_n);

   assert_no_drive_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !fl_oe_n |-> !fl_dq_oe);

   assert_strobe_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !(!fl_oe_n && !fl_we_n));

   assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (fl_ce_n && !fl_dq_oe));

   assert_res_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |=> !res_valid);

   assert_unlock_rise_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fl_boot_unlock) |-> fl_ce_n);

   assert_unlock_off_report_R7: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> !fl_boot_unlock);

endmodule

bind flash_prog_seq flash_prog_seq_chk #(
   .ADDR_W    (ADDR_W),
   .WE_LOW_CYC(WE_LOW_CYC)
) chk_i (
   .clk           (clk),
   .rst_n         (rst_n),
   .req_ready     (req_ready),
   .res_valid     (res_valid),
   .fl_ce_n       (fl_ce_n),
   .fl_oe_n       (fl_oe_n),
   .fl_we_n       (fl_we_n),
   .fl_addr       (fl_addr),
   .fl_dq_o       (fl_dq_o),
   .fl_dq_oe      (fl_dq_oe),
   .fl_boot_unlock(fl_boot_unlock)
);

// File: tb/flash_prog_seq_tb_top.sv
module flash_prog_seq_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int AW         = 17;
   localparam int WE_LOW     = 3;
   localparam int POLL       = 8;
   localparam int BOOT_SZ    = 8192;
   localparam int WDOG_LIM   = 100000;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic          req_ready;
   logic [AW-1:0] req_addr = '0;
   logic [7:0]    req_data = '0;
   logic          req_last = 1'b0;
   logic          req_check_each = 1'b0;
   logic          res_valid;
   logic [1:0]    res_code;
   logic          fl_ce_n, fl_oe_n, fl_we_n, fl_dq_oe, fl_boot_unlock;
   logic [AW-1:0] fl_addr;
   logic [7:0]    fl_dq_o;
   logic [7:0]    fl_dq_i;

   always #(CLK_PERIOD / 2) clk = ~clk;

   flash_prog_seq #(
      .ADDR_W     (AW),
      .SETUP_CYC  (2),
      .WE_LOW_CYC (WE_LOW),
      .HOLD_CYC   (1),
      .POLL_MAX   (POLL),
      .BOOT_BYTES (BOOT_SZ),
      .BOOT_AT_TOP(1'b0)
   ) dut_i (
      .clk           (clk),
      .rst_n         (rst_n),
      .req_valid     (req_valid),
      .req_ready     (req_ready),
      .req_addr      (req_addr),
      .req_data      (req_data),
      .req_last      (req_last),
      .req_check_each(req_check_each),
      .res_valid     (res_valid),
      .res_code      (res_code),
      .fl_ce_n       (fl_ce_n),
      .fl_oe_n       (fl_oe_n),
      .fl_we_n       (fl_we_n),
      .fl_addr       (fl_addr),
      .fl_dq_o       (fl_dq_o),
      .fl_dq_oe      (fl_dq_oe),
      .fl_dq_i       (fl_dq_i),
      .fl_boot_unlock(fl_boot_unlock)
   );

   int n_checks = 0;
   int n_fails  = 0;

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fails++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   // ---------------- flash model ----------------
   int   m_busy = 0;
   logic m_sr3 = 1'b0, m_sr4 = 1'b0, m_pend = 1'b0;
   int   cfg_busy = 0;
   logic cfg_e3 = 1'b0, cfg_e4 = 1'b0;
   int   read_cnt = 0;

   assign fl_dq_i = {(m_busy == 0), 2'b00, m_sr4, m_sr3, 3'b000};

   // ---------------- scoreboard queues ----------------
   typedef struct packed {
      logic [AW-1:0] addr;
      logic [7:0]    data;
      logic          unlock;
   } wr_item_t;

   wr_item_t   exp_wr_q[$];
   logic [1:0] exp_res_q[$];

   // ---------------- monitor ----------------
   logic          we_prev = 1'b1, oe_prev = 1'b1;
   int            we_low_cnt = 0;
   logic [AW-1:0] wr_addr_cap;
   logic [7:0]    wr_data_cap;
   logic          wr_unl_cap;

   always @(negedge clk) begin
      if (rst_n) begin
         if (!fl_we_n) begin
            if (we_prev) begin
               we_low_cnt  = 1;
               wr_addr_cap = fl_addr;
               wr_data_cap = fl_dq_o;
               wr_unl_cap  = fl_boot_unlock;
            end else begin
               we_low_cnt++;
               check(fl_addr == wr_addr_cap && fl_dq_o == wr_data_cap && fl_dq_oe,
                     "R9 write stable", fl_dq_o, wr_data_cap);
            end
         end
         if (fl_we_n && !we_prev) begin
            check(we_low_cnt == WE_LOW, "R9 we width", we_low_cnt, WE_LOW);
            if (exp_wr_q.size() == 0) begin
               check(1'b0, "R1 unexpected write", wr_data_cap, 0);
            end else begin
               wr_item_t e;
               e = exp_wr_q.pop_front();
               // R1 R5 R6 R7: order, address, data and unlock level of each write
               check({wr_addr_cap, wr_data_cap, wr_unl_cap} == e,
                     "R1/R5/R6/R7 write", {wr_addr_cap, wr_data_cap, wr_unl_cap}, e);
            end
            if (m_pend) begin
               m_busy = cfg_busy;
               m_sr3  = m_sr3 | cfg_e3;
               m_sr4  = m_sr4 | cfg_e4;
               m_pend = 1'b0;
            end else if (wr_data_cap == 8'h40) begin
               m_pend = 1'b1;
            end else if (wr_data_cap == 8'h50) begin
               m_sr3 = 1'b0;
               m_sr4 = 1'b0;
            end
         end
         if (!fl_oe_n) begin
            check(!fl_dq_oe && !fl_ce_n, "R2 bus released on read", fl_dq_oe, 0);
         end
         if (fl_oe_n && !oe_prev) begin
            read_cnt++;
            if (m_busy > 0) m_busy--;
         end
         if (res_valid) begin
            check(!fl_boot_unlock, "R7 unlock low at result", fl_boot_unlock, 0);
            if (exp_res_q.size() == 0) begin
               check(1'b0, "R4 unexpected result", res_code, 0);
            end else begin
               logic [1:0] er;
               er = exp_res_q.pop_front();
               check(res_code == er, "R3/R4/R8 result code", res_code, er);
            end
         end
         we_prev = fl_we_n;
         oe_prev = fl_oe_n;
      end
   end

   // ---------------- driver ----------------
   logic tb_flush = 1'b0;
   logic tb_s3 = 1'b0, tb_s4 = 1'b0;

   task automatic send(input logic [AW-1:0] a, input logic [7:0] d, input logic last,
                       input logic each, input int busy, input logic e3, input logic e4);
      int   exp_reads;
      logic boot;
      boot = (a < AW'(BOOT_SZ));
      cfg_busy = busy;
      cfg_e3   = e3;
      cfg_e4   = e4;
      if (tb_flush) begin
         exp_reads = 0;
         if (last) tb_flush = 1'b0;
      end else begin
         exp_wr_q.push_back({a, 8'h40, boot});
         exp_wr_q.push_back({a, d, boot});
         tb_s3 = tb_s3 | e3;
         tb_s4 = tb_s4 | e4;
         if (busy + 1 > POLL) begin
            exp_reads = POLL;
            exp_wr_q.push_back({a, 8'h50, 1'b0});
            exp_wr_q.push_back({a, 8'hFF, 1'b0});
            exp_res_q.push_back(2'd3);
            tb_s3 = 1'b0;
            tb_s4 = 1'b0;
            tb_flush = !last;
         end else begin
            exp_reads = busy + 1;
            if (each || last) begin
               logic [1:0] code;
               code = tb_s3 ? 2'd1 : (tb_s4 ? 2'd2 : 2'd0);
               if (code != 2'd0) begin
                  exp_wr_q.push_back({a, 8'h50, 1'b0});
                  tb_s3 = 1'b0;
                  tb_s4 = 1'b0;
               end
               if (last) exp_wr_q.push_back({a, 8'hFF, 1'b0});
               exp_res_q.push_back(code);
            end
         end
      end
      read_cnt = 0;
      @(negedge clk);
      req_addr       = a;
      req_data       = d;
      req_last       = last;
      req_check_each = each;
      req_valid      = 1'b1;
      while (!req_ready) @(negedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      while (!req_ready) @(negedge clk);
      repeat (3) @(negedge clk);
      check(read_cnt == exp_reads, "R2/R8 status read count", read_cnt, exp_reads);
   endtask

   // ---------------- watchdog ----------------
   int  wd_cnt = 0;
   logic done_flag = 1'b0;
   always @(posedge clk) begin
      wd_cnt++;
      if (wd_cnt > WDOG_LIM && !done_flag) begin
         done_flag = 1'b1;
         n_checks++;
         n_fails++;
         $display("FAIL watchdog: actual %0d expected < %0d cycles", wd_cnt, WDOG_LIM);
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R10 reset state
      check(fl_ce_n && fl_oe_n && fl_we_n, "R10 strobes idle in reset", {fl_ce_n, fl_oe_n, fl_we_n}, 3'b111);
      check(!fl_dq_oe && !fl_boot_unlock && !res_valid, "R10 outputs quiet in reset",
            {fl_dq_oe, fl_boot_unlock, res_valid}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(req_ready, "R10 ready after reset", req_ready, 1);

      // R1 R4: per-byte mode, non-boot, ok, not last (no read-array write)
      send(17'h10000, 8'hA5, 1'b0, 1'b1, 2, 1'b0, 1'b0);
      // R7 R3 R5: boot byte with supply fault
      send(17'h00100, 8'h3C, 1'b0, 1'b1, 0, 1'b1, 1'b0);
      // R3 priority: both faults, last byte -> clear then read-array (R6)
      send(17'h00200, 8'h11, 1'b1, 1'b1, 1, 1'b1, 1'b1);
      // R3 program fault only, non-boot, last
      send(17'h12345, 8'h99, 1'b1, 1'b1, 3, 1'b0, 1'b1);
      // R4 batch job, fault in middle byte accumulates
      send(17'h04000, 8'h01, 1'b0, 1'b0, 1, 1'b0, 1'b0);
      send(17'h04001, 8'h02, 1'b0, 1'b0, 3, 1'b0, 1'b1);
      send(17'h04002, 8'h03, 1'b1, 1'b0, 0, 1'b0, 1'b0);
      // R4 batch job all clean
      send(17'h1FFFE, 8'h55, 1'b0, 1'b0, 0, 1'b0, 1'b0);
      send(17'h1FFFF, 8'hAA, 1'b1, 1'b0, 2, 1'b0, 1'b0);
      // R8 boundary: busy POLL-1 still succeeds
      send(17'h00010, 8'h77, 1'b1, 1'b1, POLL - 1, 1'b0, 1'b0);
      // R8 timeout at exactly POLL reads, boot byte, then flush rest of job
      send(17'h00020, 8'h66, 1'b0, 1'b1, POLL, 1'b0, 1'b0);
      send(17'h00021, 8'h67, 1'b0, 1'b1, 0, 1'b0, 1'b0);
      send(17'h00022, 8'h68, 1'b1, 1'b1, 0, 1'b0, 1'b0);
      // R8 after flush, a new job runs normally
      send(17'h08000, 8'hC3, 1'b1, 1'b1, 1, 1'b0, 1'b0);
      // R8 timeout on batch last byte
      send(17'h09000, 8'hE1, 1'b1, 1'b0, 40, 1'b0, 1'b0);

      repeat (5) @(negedge clk);
      check(exp_wr_q.size() == 0, "R1/R6 all writes seen", exp_wr_q.size(), 0);
      check(exp_res_q.size() == 0, "R4 all results seen", exp_res_q.size(), 0);
      check(req_ready && fl_ce_n && !fl_boot_unlock, "R10 idle at end", req_ready, 1);
      done_flag = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end

endmodule